// File: doc/BRIEF.md
# Linked-List DMA Engine with Bandwidth Throttle

This block copies 32-bit words between a local memory port and a remote bus port. Software sets it up through a small register bank. In direct mode the CPU writes a local address, a remote address, a byte count and a per-command control word, then starts the engine. The engine moves one word per beat until the count is used up or a port reports an error.

In list mode the CPU writes only the local address of the first command descriptor and starts the engine. The engine then reads five-word descriptors from local memory and runs each one in turn. It follows the next-pointer of each descriptor until the pointer carries an end mark. A descriptor can request an interrupt for its own completion, and the engine raises it while the list continues. Every stop, whether on completion or on error, is reported in a status register and by a one-cycle interrupt pulse.

A pair of programmable timers limits how heavily the engine loads the remote bus. The engine may run beats for a set number of cycles. It then keeps both ports quiet for a set number of cycles before it starts the next beat.

Top module: `dmac_chain_top`

## Requirements
- R1: After reset, all eight registers read zero, no port request is active and the interrupt output is low. Registers are addressed by word index: 0 mode, 1 command control, 2 local address, 3 remote address, 4 byte count, 5 list head, 6 timers, 7 status.
- R2: In direct mode (index 0 written with bit0=1 and bit1=0) with command control bit0=0, the engine reads count/4 words from local memory starting at the local address and writes them to the remote port starting at the remote address. Both addresses advance by 4 on each beat. Only one port requests at a time, and a request holds its address until it gets an acknowledge or an error.
- R3: With command control bit0=1, the engine copies in the other direction, from the remote port to local memory, and the remote request follows the same handshake rule.
- R4: A byte count whose two low bits are not both zero stops the engine at once. Status then reads error (bit2) and misaligned count (bit5), and no data beat takes place.
- R5: A byte count of zero ends the command at once with no data beat. In direct mode the status then reads done.
- R6: Every stop clears busy (status bit0), sets exactly one of done (bit1) or error (bit2), and pulses the interrupt output high for one cycle.
- R7: In list mode (index 0 written with bits 1:0 = 2'b11), the engine fetches descriptors from the list head. Each descriptor is five words in this order: control, local address, remote address, byte count, next pointer. A next pointer with bit0=1 ends the list. Commands run in list order.
- R8: A descriptor whose control bit1 is set causes a one-cycle interrupt pulse when its command finishes and the list continues. The last command produces only the single stop pulse.
- R9: An error response on either port, including during a descriptor fetch, stops the engine. The status then reads error plus local-port fault (bit3) or remote-port fault (bit4).
- R10: While busy, writes to indices 0 to 6 are ignored. After a list run, index 1 reads back the control word of the last descriptor loaded.
- R11: Index 6 holds the on-time in bits 15:0 and the off-time in bits 31:16, and an on-time of zero disables throttling. Once the beat cycles reach the on-time, no new beat starts and the remote request stays low for at least off-time cycles.
- R12: A start write accepted while idle clears all status bits from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| loc_req | output | 1 | Local port request |
| loc_we | output | 1 | Local port write enable |
| loc_addr | output | 32 | Local port byte address |
| loc_wdata | output | 32 | Local port write data |
| loc_ack | input | 1 | Local port acknowledge |
| loc_err | input | 1 | Local port error response |
| loc_rdata | input | 32 | Local port read data, valid with loc_ack |
| rem_req | output | 1 | Remote port request |
| rem_we | output | 1 | Remote port write enable |
| rem_addr | output | 32 | Remote port byte address |
| rem_wdata | output | 32 | Remote port write data |
| rem_ack | input | 1 | Remote port acknowledge |
| rem_err | input | 1 | Remote port error response |
| rem_rdata | input | 32 | Remote port read data, valid with rem_ack |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Register reads are combinational, so the bench samples reg_rdata 1 ns after the falling edge that sets the index. Busy rises at the first rising edge after the start write. Each beat takes the responder latency plus one cycle per port, and status and irq change at the same edge that takes the final acknowledge or error. For that reason the bench does not count cycles for whole transfers. It polls the status register at falling edges until busy clears, and only then compares memory, status and the interrupt count. Interrupt pulses and the gaps in remote requests are counted at every falling edge, which covers each one-cycle event exactly once.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int CTL_W      = 2;
   localparam int DESC_WORDS = 5;
   localparam int STAT_W     = 6;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_CMDEND
   } dmac_state_e;

   localparam logic [2:0] RI_MODE  = 3'd0;
   localparam logic [2:0] RI_CTL   = 3'd1;
   localparam logic [2:0] RI_LADDR = 3'd2;
   localparam logic [2:0] RI_RADDR = 3'd3;
   localparam logic [2:0] RI_COUNT = 3'd4;
   localparam logic [2:0] RI_HEAD  = 3'd5;
   localparam logic [2:0] RI_TIMER = 3'd6;
   localparam logic [2:0] RI_STAT  = 3'd7;
endpackage

// File: rtl/dmac_csr.sv
module dmac_csr
   import dmac_pkg::*;
#(
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [2:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               busy,
   input  logic [STAT_W-1:0]  status,
   input  logic               ctl_ld,
   input  logic [CTL_W-1:0]   ctl_val,
   output logic               start,
   output logic               start_chain,
   output logic [CTL_W-1:0]   cfg_ctl,
   output logic [31:0]        cfg_laddr,
   output logic [31:0]        cfg_raddr,
   output logic [31:0]        cfg_count,
   output logic [31:0]        cfg_head,
   output logic [TIMER_W-1:0] on_time,
   output logic [TIMER_W-1:0] off_time
);
   logic        chain_q;
   logic [31:0] tmr_q;
   logic        wr_ok;

   assign wr_ok       = reg_wr && !busy;
   assign start       = wr_ok && (reg_addr == RI_MODE) && reg_wdata[0];
   assign start_chain = reg_wdata[1];
   assign on_time     = tmr_q[TIMER_W-1:0];
   assign off_time    = tmr_q[16 +: TIMER_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q   <= 1'b0;
         cfg_ctl   <= '0;
         cfg_laddr <= '0;
         cfg_raddr <= '0;
         cfg_count <= '0;
         cfg_head  <= '0;
         tmr_q     <= '0;
      end else begin
         if (wr_ok) begin
            unique case (reg_addr)
               RI_MODE:  chain_q   <= reg_wdata[1];
               RI_CTL:   cfg_ctl   <= reg_wdata[CTL_W-1:0];
               RI_LADDR: cfg_laddr <= reg_wdata;
               RI_RADDR: cfg_raddr <= reg_wdata;
               RI_COUNT: cfg_count <= reg_wdata;
               RI_HEAD:  cfg_head  <= reg_wdata;
               RI_TIMER: tmr_q     <= reg_wdata;
               default:  ;
            endcase
         end
         if (ctl_ld) cfg_ctl <= ctl_val;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RI_MODE:  reg_rdata[1]         = chain_q;
         RI_CTL:   reg_rdata[CTL_W-1:0] = cfg_ctl;
         RI_LADDR: reg_rdata            = cfg_laddr;
         RI_RADDR: reg_rdata            = cfg_raddr;
         RI_COUNT: reg_rdata            = cfg_count;
         RI_HEAD:  reg_rdata            = cfg_head;
         RI_TIMER: reg_rdata            = tmr_q;
         default:  reg_rdata[STAT_W-1:0] = status;
      endcase
   end
endmodule

// File: rtl/dmac_throttle.sv
module dmac_throttle #(
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               beat,
   input  logic               gap,
   input  logic [TIMER_W-1:0] on_time,
   input  logic [TIMER_W-1:0] off_time,
   output logic               allow,
   output logic               holding
);
   logic [TIMER_W-1:0] on_cnt;
   logic [TIMER_W-1:0] off_cnt;
   logic               expired;

   assign expired = (on_time != '0) && (on_cnt >= on_time);
   assign holding = (off_cnt != '0);
   assign allow   = !holding && !expired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_cnt  <= '0;
         off_cnt <= '0;
      end else if (!run) begin
         on_cnt  <= '0;
         off_cnt <= '0;
      end else if (holding) begin
         off_cnt <= off_cnt - 1'b1;
      end else if (expired && gap) begin
         off_cnt <= off_time;
         on_cnt  <= '0;
      end else if (beat && (on_cnt != '1)) begin
         on_cnt <= on_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
   import dmac_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_chain,
   input  logic [CTL_W-1:0]  cfg_ctl,
   input  logic [31:0]       cfg_laddr,
   input  logic [31:0]       cfg_raddr,
   input  logic [31:0]       cfg_count,
   input  logic [31:0]       cfg_head,
   input  logic              allow,
   output logic              loc_req,
   output logic              loc_we,
   output logic [31:0]       loc_addr,
   output logic [31:0]       loc_wdata,
   input  logic              loc_ack,
   input  logic              loc_err,
   input  logic [31:0]       loc_rdata,
   output logic              rem_req,
   output logic              rem_we,
   output logic [31:0]       rem_addr,
   output logic [31:0]       rem_wdata,
   input  logic              rem_ack,
   input  logic              rem_err,
   input  logic [31:0]       rem_rdata,
   output logic              busy,
   output logic              in_beat,
   output logic              in_gap,
   output logic [STAT_W-1:0] status,
   output logic              ctl_ld,
   output logic [CTL_W-1:0]  ctl_val,
   output logic              irq
);
   localparam int          IDX_W     = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);
   localparam logic [31:0] STEP      = 32'd4;

   dmac_state_e      state;
   logic             chain_m;
   logic [31:0]      cur_l, cur_r, cur_cnt, next_ptr, desc_ptr, buf_q;
   logic [CTL_W-1:0] cur_ctl;
   logic [IDX_W-1:0] widx;
   logic             done_q, err_q, eloc, erem, ealign, irq_q;
   logic             dir;
   logic             rd_ack, rd_err, wr_ack, wr_err;
   logic [31:0]      rd_data;

   assign dir       = cur_ctl[0];
   assign loc_req   = (state == ST_FETCH) || (state == ST_READ && !dir) || (state == ST_WRITE && dir);
   assign loc_we    = (state == ST_WRITE) && dir;
   assign loc_addr  = (state == ST_FETCH) ? desc_ptr + {{(30-IDX_W){1'b0}}, widx, 2'b00} : cur_l;
   assign loc_wdata = buf_q;
   assign rem_req   = (state == ST_READ && dir) || (state == ST_WRITE && !dir);
   assign rem_we    = (state == ST_WRITE) && !dir;
   assign rem_addr  = cur_r;
   assign rem_wdata = buf_q;

   assign rd_ack  = dir ? rem_ack : loc_ack;
   assign rd_err  = dir ? rem_err : loc_err;
   assign rd_data = dir ? rem_rdata : loc_rdata;
   assign wr_ack  = dir ? loc_ack : rem_ack;
   assign wr_err  = dir ? loc_err : rem_err;

   assign busy    = (state != ST_IDLE);
   assign in_beat = (state == ST_READ) || (state == ST_WRITE);
   assign in_gap  = (state == ST_CHECK);
   assign status  = {ealign, erem, eloc, err_q, done_q, busy};
   assign ctl_ld  = (state == ST_FETCH) && (widx == '0) && loc_ack && !loc_err;
   assign ctl_val = loc_rdata[CTL_W-1:0];
   assign irq     = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         chain_m  <= 1'b0;
         cur_l    <= '0;
         cur_r    <= '0;
         cur_cnt  <= '0;
         cur_ctl  <= '0;
         next_ptr <= '0;
         desc_ptr <= '0;
         buf_q    <= '0;
         widx     <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         eloc     <= 1'b0;
         erem     <= 1'b0;
         ealign   <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               done_q  <= 1'b0;
               err_q   <= 1'b0;
               eloc    <= 1'b0;
               erem    <= 1'b0;
               ealign  <= 1'b0;
               chain_m <= start_chain;
               if (start_chain) begin
                  desc_ptr <= {cfg_head[31:2], 2'b00};
                  widx     <= '0;
                  state    <= ST_FETCH;
               end else begin
                  cur_l   <= cfg_laddr;
                  cur_r   <= cfg_raddr;
                  cur_cnt <= cfg_count;
                  cur_ctl <= cfg_ctl;
                  state   <= ST_CHECK;
               end
            end
            ST_FETCH: if (loc_err) begin
               err_q <= 1'b1; eloc <= 1'b1; irq_q <= 1'b1; state <= ST_IDLE;
            end else if (loc_ack) begin
               unique case (widx)
                  IDX_W'(0): cur_ctl  <= loc_rdata[CTL_W-1:0];
                  IDX_W'(1): cur_l    <= loc_rdata;
                  IDX_W'(2): cur_r    <= loc_rdata;
                  IDX_W'(3): cur_cnt  <= loc_rdata;
                  default:   next_ptr <= loc_rdata;
               endcase
               if (widx == IDX_LAST) state <= ST_CHECK;
               else                  widx  <= widx + 1'b1;
            end
            ST_CHECK: if (cur_cnt[1:0] != 2'b00) begin
               err_q <= 1'b1; ealign <= 1'b1; irq_q <= 1'b1; state <= ST_IDLE;
            end else if (cur_cnt == '0) begin
               state <= ST_CMDEND;
            end else if (allow) begin
               state <= ST_READ;
            end
            ST_READ: if (rd_err) begin
               err_q <= 1'b1; erem <= dir; eloc <= !dir; irq_q <= 1'b1; state <= ST_IDLE;
            end else if (rd_ack) begin
               buf_q <= rd_data;
               state <= ST_WRITE;
            end
            ST_WRITE: if (wr_err) begin
               err_q <= 1'b1; eloc <= dir; erem <= !dir; irq_q <= 1'b1; state <= ST_IDLE;
            end else if (wr_ack) begin
               cur_l   <= cur_l + STEP;
               cur_r   <= cur_r + STEP;
               cur_cnt <= cur_cnt - STEP;
               state   <= ST_CHECK;
            end
            ST_CMDEND: if (chain_m && !next_ptr[0]) begin
               irq_q    <= cur_ctl[1];
               desc_ptr <= {next_ptr[31:2], 2'b00};
               widx     <= '0;
               state    <= ST_FETCH;
            end else begin
               done_q <= 1'b1; irq_q <= 1'b1; state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dmac_chain_top.sv
module dmac_chain_top
   import dmac_pkg::*;
#(
   parameter int TIMER_W     = 16,
   parameter bit THROTTLE_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        loc_req,
   output logic        loc_we,
   output logic [31:0] loc_addr,
   output logic [31:0] loc_wdata,
   input  logic        loc_ack,
   input  logic        loc_err,
   input  logic [31:0] loc_rdata,
   output logic        rem_req,
   output logic        rem_we,
   output logic [31:0] rem_addr,
   output logic [31:0] rem_wdata,
   input  logic        rem_ack,
   input  logic        rem_err,
   input  logic [31:0] rem_rdata,
   output logic        irq
);
   if (TIMER_W < 1 || TIMER_W > 16) begin : g_bad_timer_w
      $error("dmac_chain_top: TIMER_W must lie in 1..16");
   end

   logic                start, start_chain, eng_busy, in_beat, in_gap;
   logic                ctl_ld, allow, thr_hold;
   logic [CTL_W-1:0]    ctl_val, cfg_ctl;
   logic [STAT_W-1:0]   eng_status;
   logic [31:0]         cfg_laddr, cfg_raddr, cfg_count, cfg_head;
   logic [TIMER_W-1:0]  on_time, off_time;

   dmac_csr #(.TIMER_W(TIMER_W)) u_csr (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .busy(eng_busy), .status(eng_status), .ctl_ld, .ctl_val,
      .start, .start_chain, .cfg_ctl, .cfg_laddr, .cfg_raddr,
      .cfg_count, .cfg_head, .on_time, .off_time
   );

   if (THROTTLE_EN) begin : g_throttle
      dmac_throttle #(.TIMER_W(TIMER_W)) u_thr (
         .clk, .rst_n, .run(eng_busy), .beat(in_beat), .gap(in_gap),
         .on_time, .off_time, .allow, .holding(thr_hold)
      );
   end else begin : g_no_throttle
      assign allow    = 1'b1;
      assign thr_hold = 1'b0;
   end

   dmac_engine u_eng (
      .clk, .rst_n, .start, .start_chain, .cfg_ctl, .cfg_laddr, .cfg_raddr,
      .cfg_count, .cfg_head, .allow,
      .loc_req, .loc_we, .loc_addr, .loc_wdata, .loc_ack, .loc_err, .loc_rdata,
      .rem_req, .rem_we, .rem_addr, .rem_wdata, .rem_ack, .rem_err, .rem_rdata,
      .busy(eng_busy), .in_beat, .in_gap, .status(eng_status),
      .ctl_ld, .ctl_val, .irq
   );
endmodule

// File: rtl/dmac_chain_chk.sv
module dmac_chain_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        loc_req,
   input logic        loc_ack,
   input logic        loc_err,
   input logic [31:0] loc_addr,
   input logic        rem_req,
   input logic        rem_ack,
   input logic        rem_err,
   input logic [31:0] rem_addr,
   input logic        irq,
   input logic        busy,
   input logic        holding,
   input logic        reg_wr,
   input logic [2:0]  reg_addr,
   input logic [31:0] cfg_count,
   input logic [5:0]  status
);
   p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_req && rem_req));

   p_loc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_req && !loc_ack && !loc_err) |=> (loc_req && $stable(loc_addr)));

   p_rem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_req && !rem_ack && !rem_err) |=> (rem_req && $stable(rem_addr)));

   p_stop_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq);

   p_done_xor_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[1] && status[2]));

   p_hold_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      holding |-> !rem_req);

   p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr == 3'd4) |=> $stable(cfg_count));
endmodule

bind dmac_chain_top dmac_chain_chk u_chk (
   .clk(clk), .rst_n(rst_n), .loc_req(loc_req), .loc_ack(loc_ack),
   .loc_err(loc_err), .loc_addr(loc_addr), .rem_req(rem_req),
   .rem_ack(rem_ack), .rem_err(rem_err), .rem_addr(rem_addr), .irq(irq),
   .busy(eng_busy), .holding(thr_hold), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .cfg_count(cfg_count), .status(eng_status)
);

// File: tb/tb_dmac_chain_top.sv
`timescale 1ns/1ps
module tb_dmac_chain_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        loc_req, loc_we, rem_req, rem_we, irq;
   logic [31:0] loc_addr, loc_wdata, rem_addr, rem_wdata;
   logic        loc_ack, loc_err, rem_ack, rem_err;
   logic [31:0] loc_rdata, rem_rdata;

   logic [31:0] lmem [256];
   logic [31:0] rmem [256];
   logic [31:0] loc_bad = 32'hFFFF_FFFF;
   logic [31:0] rem_bad = 32'hFFFF_FFFF;

   int errors = 0, checks = 0, irq_cnt = 0, acks = 0;
   int gap = 0, max_gap = 0;
   bit seen = 0, finished = 0;

   always #2.5 clk = ~clk;

   dmac_chain_top dut (.*);

   always @(posedge clk) begin
      if (!rst_n) begin
         loc_ack <= 1'b0; loc_err <= 1'b0; loc_rdata <= '0;
      end else begin
         loc_ack <= 1'b0; loc_err <= 1'b0;
         if (loc_req && !loc_ack && !loc_err) begin
            if (loc_addr == loc_bad) loc_err <= 1'b1;
            else begin
               loc_ack <= 1'b1;
               if (loc_we) lmem[loc_addr[9:2]] <= loc_wdata;
               else        loc_rdata <= lmem[loc_addr[9:2]];
            end
         end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         rem_ack <= 1'b0; rem_err <= 1'b0; rem_rdata <= '0;
      end else begin
         rem_ack <= 1'b0; rem_err <= 1'b0;
         if (rem_req && !rem_ack && !rem_err) begin
            if (rem_addr == rem_bad) rem_err <= 1'b1;
            else begin
               rem_ack <= 1'b1;
               if (rem_we) rmem[rem_addr[9:2]] <= rem_wdata;
               else        rem_rdata <= rmem[rem_addr[9:2]];
            end
         end
      end
   end

   always @(negedge clk) begin
      if (irq) irq_cnt++;
      if (loc_ack || rem_ack) acks++;
      if (rem_req) begin
         if (seen && gap > max_gap) max_gap = gap;
         gap = 0; seen = 1;
      end else if (seen) gap++;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] s;
      int t = 0;
      do begin rd(3'd7, s); t++; end while (s[0] && t < 5000);
      if (s[0]) chk(tag, s, 32'h0);
   endtask

   function automatic logic [31:0] sentinel(input int i);
      return 32'hDEAD_0000 + 32'(i);
   endfunction

   task automatic clear_mon();
      irq_cnt = 0; acks = 0; gap = 0; max_gap = 0; seen = 0;
   endtask

   task automatic run_direct(input logic dir, input int li, input int ri, input int n, input string tag);
      logic [31:0] s;
      int mism = 0;
      for (int i = 0; i < n; i++) begin
         if (!dir) begin lmem[li+i] = $urandom; rmem[ri+i] = sentinel(i); end
         else      begin rmem[ri+i] = $urandom; lmem[li+i] = sentinel(i); end
      end
      if (!dir) rmem[ri+n] = sentinel(n); else lmem[li+n] = sentinel(n);
      wr(3'd1, {31'b0, dir});
      wr(3'd2, 32'(li*4));
      wr(3'd3, 32'(ri*4));
      wr(3'd4, 32'(n*4));
      clear_mon();
      wr(3'd0, 32'h1);
      wait_idle(tag);
      for (int i = 0; i < n; i++)
         if ((!dir && rmem[ri+i] !== lmem[li+i]) || (dir && lmem[li+i] !== rmem[ri+i])) mism++;
      chk({tag, " data"}, 32'(mism), 32'h0);
      chk({tag, " past end"}, dir ? lmem[li+n] : rmem[ri+n], sentinel(n));
      rd(3'd7, s);
      chk({tag, " status done"}, s, 32'h2);
      chk({tag, " R6 irq count"}, 32'(irq_cnt), 32'h1);
   endtask

   initial begin
      logic [31:0] s;
      logic [31:0] exp_w [6];
      void'($urandom(32'd1234));
      for (int i = 0; i < 256; i++) begin lmem[i] = '0; rmem[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), s);
         chk("R1 register zero", s, 32'h0);
      end
      chk("R1 ports idle", {29'b0, loc_req, rem_req, irq}, 32'h0);

      // R2 / R3: directed and random direct transfers
      run_direct(1'b0, 0, 0, 1, "R2");
      run_direct(1'b1, 10, 20, 16, "R3");
      for (int k = 0; k < 6; k++) begin
         automatic logic d = 1'($urandom % 2);
         run_direct(d, int'($urandom % 64), 64 + int'($urandom % 64),
                    1 + int'($urandom % 16), d ? "R3" : "R2");
      end

      // R5: zero count
      wr(3'd4, 32'h0); clear_mon(); wr(3'd0, 32'h1); wait_idle("R5");
      rd(3'd7, s);
      chk("R5 status done", s, 32'h2);
      chk("R5 no beats", 32'(acks), 32'h0);

      // R4: misaligned count
      wr(3'd4, 32'd6); clear_mon(); wr(3'd0, 32'h1); wait_idle("R4");
      rd(3'd7, s);
      chk("R4 status err+align", s, 32'h24);
      chk("R4 no beats", 32'(acks), 32'h0);
      chk("R4 R6 irq", 32'(irq_cnt), 32'h1);

      // R12: a new start clears error status
      run_direct(1'b0, 2, 100, 3, "R12");

      // R9: remote error on third beat
      for (int i = 0; i < 4; i++) rmem[150+i] = sentinel(i);
      rem_bad = 32'((150+2)*4);
      wr(3'd1, 32'h0); wr(3'd2, 32'h0); wr(3'd3, 32'(150*4)); wr(3'd4, 32'd16);
      clear_mon(); wr(3'd0, 32'h1); wait_idle("R9");
      rd(3'd7, s);
      chk("R9 status remote fault", s, 32'h14);
      chk("R9 beat before fault", rmem[151], lmem[1]);
      chk("R9 faulty word untouched", rmem[152], sentinel(2));
      chk("R9 R6 irq", 32'(irq_cnt), 32'h1);
      rem_bad = 32'hFFFF_FFFF;

      // R10: writes ignored while busy
      wr(3'd1, 32'h0); wr(3'd2, 32'h0); wr(3'd3, 32'(200*4)); wr(3'd4, 32'd64);
      wr(3'd0, 32'h1);
      wr(3'd4, 32'd4); wr(3'd1, 32'h1); wr(3'd2, 32'h300);
      wait_idle("R10");
      rd(3'd4, s); chk("R10 count kept", s, 32'd64);
      rd(3'd1, s); chk("R10 control kept", s, 32'h0);
      rd(3'd2, s); chk("R10 local addr kept", s, 32'h0);

      // R7 / R8: three-descriptor list
      for (int i = 0; i < 6; i++) lmem[i] = $urandom;
      for (int i = 0; i < 5; i++) rmem[10+i] = $urandom;
      for (int i = 0; i < 5; i++) lmem[20+i] = sentinel(i);
      lmem[128] = 32'h2; lmem[129] = 32'h000; lmem[130] = 32'h000; lmem[131] = 32'd16; lmem[132] = 32'h240;
      lmem[144] = 32'h1; lmem[145] = 32'h050; lmem[146] = 32'h028; lmem[147] = 32'd20; lmem[148] = 32'h280;
      lmem[160] = 32'h2; lmem[161] = 32'h010; lmem[162] = 32'h008; lmem[163] = 32'd8;  lmem[164] = 32'h1;
      exp_w[0] = lmem[0]; exp_w[1] = lmem[1]; exp_w[2] = lmem[4]; exp_w[3] = lmem[5];
      wr(3'd5, 32'h200); clear_mon(); wr(3'd0, 32'h3); wait_idle("R7");
      rd(3'd7, s); chk("R7 list status done", s, 32'h2);
      for (int i = 0; i < 4; i++) chk("R7 list order remote", rmem[i], exp_w[i]);
      for (int i = 0; i < 5; i++) chk("R7 reverse command", lmem[20+i], rmem[10+i]);
      chk("R8 per-command irq count", 32'(irq_cnt), 32'h2);
      rd(3'd1, s); chk("R10 control from last descriptor", s, 32'h2);
      rd(3'd0, s); chk("R7 mode readback", s, 32'h2);

      // R9: local error during descriptor fetch
      loc_bad = 32'h244;
      clear_mon(); wr(3'd0, 32'h3); wait_idle("R9");
      rd(3'd7, s); chk("R9 status local fault", s, 32'h0C);
      chk("R8 R9 irq count", 32'(irq_cnt), 32'h2);
      loc_bad = 32'hFFFF_FFFF;

      // R11: throttle on and off
      wr(3'd6, {16'd30, 16'd6});
      run_direct(1'b0, 40, 60, 16, "R11");
      chk("R11 off gap seen", 32'(max_gap >= 30), 32'h1);
      wr(3'd6, 32'h0);
      run_direct(1'b0, 40, 60, 16, "R11");
      chk("R11 no gap when disabled", 32'(max_gap < 30), 32'h1);

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule